// File: doc/BRIEF.md
# Watchdog Timer with Timed Reconfiguration Lock

This block is a watchdog timer whose control state is protected against stray software writes. A free-running tick counter is compared with a timeout chosen by a 3-bit scale field. When the counter reaches that timeout, the block emits a one-cycle reset request (`bite`). Software keeps the system alive by pulsing `kick`, which restarts the count.

Changing the timeout needs a two-step sequence. The same applies to stopping a running watchdog. First comes an unlock write, with the change bit and the run bit both at one. A second write with the change bit at zero must then follow within four clock cycles. If it does not, the lock closes again.

An elaboration-time parameter `LEVEL` selects one of two protection schemes:

- **Level 1:** the watchdog starts stopped and may be started by any plain write.
- **Level 2:** the watchdog always runs. Only the scale can be changed, through the sequence.

Top module: `wdt_guarded`

## Requirements
- R1: After reset the scale reads 0, the unlock flag reads 0 and `bite` is low. In level 1 `rd_run` reads 0. In level 2 it reads 1.
- R2: In level 1, a write with `wr_run`=1 and `wr_unlock`=0 outside an unlock window starts the watchdog and leaves the scale unchanged. A write with `wr_run`=0 outside a window does not stop it.
- R3: A write with `wr_unlock`=1 and `wr_run`=1 opens a fresh unlock window, and `rd_unlock` then reads 1. A write with `wr_unlock`=1 and `wr_run`=0 opens none.
- R4: A write with `wr_unlock`=0 in the 1st to 4th cycle after the unlock write is accepted. In level 1 it loads both the scale and the run bit. The window then closes at once, and `rd_unlock` reads 0.
- R5: With no accepted write, `rd_unlock` falls after the 4th cycle. Later writes to the scale, and level-1 stop attempts, then have no effect.
- R6: In level 2, `rd_run` always reads 1. An accepted write changes only the scale and ignores its run bit.
- R7: While running, `bite` is high for exactly one cycle, 2^(scale+BASE_EXP) cycles after the counter was last cleared, and this repeats with that period.
- R8: A `kick`, or an accepted reconfiguration write, clears the counter, so the next `bite` comes a full timeout later.
- R9: While stopped, `bite` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Control register write strobe |
| wr_run | input | 1 | Written run (enable) bit |
| wr_unlock | input | 1 | Written change-enable bit |
| wr_scale | input | SEL_W | Written timeout scale |
| kick | input | 1 | Counter clear strobe |
| rd_run | output | 1 | Run bit readback |
| rd_unlock | output | 1 | High while the unlock window is open |
| rd_scale | output | SEL_W | Scale readback |
| bite | output | 1 | One-cycle timeout reset request |

## Verification
The bench builds two instances side by side, one with `LEVEL`=1 and one with `LEVEL`=2, so both protection schemes are covered in a single run. Both use `BASE_EXP`=2 rather than the default 10. This shrinks timeouts to between 4 and 512 cycles, so exact timeout periods, repeated bites and kicks in mid-count can all be measured cycle by cycle. The window edges are exercised in both directions: a write on the 4th cycle after unlock is accepted, and a write on the 5th is not.

// File: rtl/wdt_guarded.sv
module wdt_guarded #(
  parameter int LEVEL    = 1,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 10,
  parameter int WIN      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             wr_run,
  input  logic             wr_unlock,
  input  logic [SEL_W-1:0] wr_scale,
  input  logic             kick,
  output logic             rd_run,
  output logic             rd_unlock,
  output logic [SEL_W-1:0] rd_scale,
  output logic             bite
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;
  localparam int WIN_W = $clog2(WIN + 1);

  logic [WIN_W-1:0] win_q;
  logic [SEL_W-1:0] scale_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             bite_q;

  wire win_open = win_q != '0;
  wire open_wr  = wr_stb && wr_unlock && wr_run;
  wire apply_wr = wr_stb && !wr_unlock && win_open;
  wire clr      = kick || apply_wr || !run_q;

  wire [CNT_W:0] limit = (CNT_W+1)'(1) << (BASE_EXP + int'(scale_q));
  wire [CNT_W:0] term  = limit - (CNT_W+1)'(1);
  wire           hit   = {1'b0, cnt_q} == term;

  always_ff @(posedge clk) begin
    if (!rst_n)
      win_q <= '0;
    else if (open_wr)
      win_q <= WIN_W'(WIN);
    else if (apply_wr)
      win_q <= '0;
    else if (win_open)
      win_q <= win_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      scale_q <= '0;
    else if (apply_wr)
      scale_q <= wr_scale;
  end

  generate
    if (LEVEL == 2) begin : g_locked
      always_ff @(posedge clk) run_q <= 1'b1;
    end else begin : g_free
      always_ff @(posedge clk) begin
        if (!rst_n)
          run_q <= 1'b0;
        else if (apply_wr)
          run_q <= wr_run;
        else if (wr_stb && wr_run)
          run_q <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bite_q <= 1'b0;
    end else begin
      bite_q <= !clr && hit;
      if (clr || hit)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rd_run    = (LEVEL == 2) ? 1'b1 : run_q;
  assign rd_unlock = win_open;
  assign rd_scale  = scale_q;
  assign bite      = bite_q;
endmodule

// File: rtl/wdt_guarded_chk.sv
module wdt_guarded_chk #(
  parameter int LEVEL = 1,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             wr_run,
  input logic             wr_unlock,
  input logic             kick,
  input logic             rd_run,
  input logic             rd_unlock,
  input logic [SEL_W-1:0] rd_scale,
  input logic             bite
);
  p_bite_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> !bite);

  p_kick_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !bite);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_run |-> !bite);

  p_scale_needs_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_scale) |-> $past(rd_unlock));

  p_open_needs_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_unlock) |-> $past(wr_stb && wr_unlock && wr_run));

  generate
    if (LEVEL == 2) begin : g_l2
      p_always_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_run);
    end else begin : g_l1
      p_stop_needs_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_run) |-> $past(rd_unlock));
    end
  endgenerate
endmodule

bind wdt_guarded wdt_guarded_chk #(.LEVEL(LEVEL), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_run(wr_run),
  .wr_unlock(wr_unlock), .kick(kick), .rd_run(rd_run),
  .rd_unlock(rd_unlock), .rd_scale(rd_scale), .bite(bite)
);

// File: tb/wdt_guarded_tb_top.sv
module wdt_guarded_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       a_stb = 0, a_run = 0, a_unl = 0, a_kick = 0;
  logic [2:0] a_sc = '0;
  logic       a_rrun, a_runl, a_bite;
  logic [2:0] a_rsc;
  logic       b_stb = 0, b_run = 0, b_unl = 0, b_kick = 0;
  logic [2:0] b_sc = '0;
  logic       b_rrun, b_runl, b_bite;
  logic [2:0] b_rsc;

  wdt_guarded #(.LEVEL(1), .SEL_W(3), .BASE_EXP(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(a_stb), .wr_run(a_run), .wr_unlock(a_unl),
    .wr_scale(a_sc), .kick(a_kick), .rd_run(a_rrun), .rd_unlock(a_runl),
    .rd_scale(a_rsc), .bite(a_bite));

  wdt_guarded #(.LEVEL(2), .SEL_W(3), .BASE_EXP(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(b_stb), .wr_run(b_run), .wr_unlock(b_unl),
    .wr_scale(b_sc), .kick(b_kick), .rd_run(b_rrun), .rd_unlock(b_runl),
    .rd_scale(b_rsc), .bite(b_bite));

  int checks = 0, errors = 0;
  bit done = 0;

  // {stb, run, unlock, scale[3], exp_run, exp_unlock, exp_scale[3], pad}
  localparam logic [11:0] VEC [17] = '{
    12'b1_1_0_101_1_0_000_0,
    12'b1_0_0_011_1_0_000_0,
    12'b1_1_1_111_1_1_000_0,
    12'b0_0_0_000_1_1_000_0,
    12'b1_1_0_011_1_0_011_0,
    12'b1_1_1_000_1_1_011_0,
    12'b0_0_0_000_1_1_011_0,
    12'b0_0_0_000_1_1_011_0,
    12'b0_0_0_000_1_1_011_0,
    12'b1_0_0_001_0_0_001_0,
    12'b1_1_1_000_1_1_001_0,
    12'b0_0_0_000_1_1_001_0,
    12'b0_0_0_000_1_1_001_0,
    12'b0_0_0_000_1_1_001_0,
    12'b0_0_0_000_1_0_001_0,
    12'b1_0_0_110_1_0_001_0,
    12'b1_0_1_010_1_0_001_0
  };

  function automatic string row_req(input int r);
    if (r < 2) return "R2";
    if (r == 4 || r == 9) return "R4";
    if (r == 14 || r == 15) return "R5";
    return "R3";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wa(input logic s, input logic r, input logic u, input logic [2:0] sc);
    @(negedge clk);
    a_stb = s; a_run = r; a_unl = u; a_sc = sc;
    @(posedge clk); #1;
    a_stb = 0; a_run = 0; a_unl = 0; a_sc = '0;
  endtask

  task automatic wb(input logic s, input logic r, input logic u, input logic [2:0] sc);
    @(negedge clk);
    b_stb = s; b_run = r; b_unl = u; b_sc = sc;
    @(posedge clk); #1;
    b_stb = 0; b_run = 0; b_unl = 0; b_sc = '0;
  endtask

  task automatic kick_a();
    @(negedge clk); a_kick = 1;
    @(posedge clk); #1; a_kick = 0;
  endtask

  task automatic measure(input bit second, output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1; n++;
      if (second ? b_bite : a_bite) break;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int bites;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 run L1", a_rrun, 0);
    check("R1 unlock L1", a_runl, 0);
    check("R1 scale L1", a_rsc, 0);
    check("R1 bite L1", a_bite, 0);
    check("R1 run L2", b_rrun, 1);
    check("R1 scale L2", b_rsc, 0);

    for (int r = 0; r < 17; r++) begin
      logic [11:0] v;
      v = VEC[r];
      wa(v[11], v[10], v[9], v[8:6]);
      check({row_req(r), " run"}, a_rrun, v[5]);
      check({row_req(r), " unlock"}, a_runl, v[4]);
      check({row_req(r), " scale"}, a_rsc, v[3:1]);
    end

    kick_a();
    measure(0, n); check("R7 first timeout scale1", n, 8);
    measure(0, n); check("R7 repeat period", n, 8);
    kick_a();
    repeat (5) @(posedge clk);
    #1 kick_a();
    measure(0, n); check("R8 kick mid-count", n, 8);
    wa(1, 1, 1, 0);
    repeat (3) @(posedge clk);
    wa(1, 1, 0, 3);
    measure(0, n); check("R8 reconfig clears, R7 scale3", n, 32);
    wa(1, 1, 1, 0);
    wa(1, 0, 0, 3);
    check("R4 level1 stop accepted", a_rrun, 0);
    bites = 0;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      if (a_bite) bites++;
    end
    check("R9 no bite while stopped", bites, 0);

    wb(1, 0, 0, 5);
    check("R6 stop write ignored", b_rrun, 1);
    check("R6 scale not changed", b_rsc, 0);
    wb(1, 0, 1, 0);
    check("R6 unlock needs run bit", b_runl, 0);
    wb(1, 1, 1, 0);
    check("R3 level2 window opens", b_runl, 1);
    wb(1, 0, 0, 2);
    check("R6 scale applied", b_rsc, 2);
    check("R6 run stays", b_rrun, 1);
    check("R4 window closed", b_runl, 0);
    measure(1, n); check("R7 level2 scale2", n, 16);
    measure(1, n); check("R7 level2 repeat", n, 16);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule